// File: doc/BRIEF.md
# Serial Interrupt Peripheral Encoder

This block is the peripheral end of a shared, single-wire, open-drain interrupt line that runs on the bus clock. It takes sixteen interrupt levels and one I/O-check level. After every Start Frame it sends them one after another, each in its own three-clock time slot. The line is modelled as a drive enable and a drive value going out, plus the resolved line level coming back in. Pull-ups and the host side of the wire are outside the block.

The block follows the line to find Start and Stop Frames. From the width of the Stop pulse it learns whether the host runs in Quiet or Continuous mode. In Quiet mode, while the line is Idle, the block can open a cycle itself when an enabled input no longer matches the value it sent last. The block has no data stream with flow control. Each input is a plain level that is captured once per cycle, and back-pressure does not apply.

Top module: `sirq_encoder`

## Requirements
- R1: While reset is low and on the first clock after it, `line_oe` is 0 and `quiet_mode` is 0 (Continuous mode).
- R2: Let h be the first clock in which the line is high after a Start low pulse. The Sample clock of slot k then falls in clock h+2+3k. Slot k is IRQ k for k = 0..15, and slot 16 is the I/O-check input, whose level sits at bit 16 of the slot vector.
- R3: For an enabled slot whose captured level is 0, the block drives 0 in the Sample clock and drives 1 in the Recovery clock (`line_oe`=1). It releases the line in the Turn-around clock.
- R4: A slot whose captured level is 1, or whose `slot_en` bit is 0, is not driven in any of its three clocks.
- R5: The levels sent in a cycle are those present in clock h+1. A change to the inputs after that clock has no effect on the current cycle.
- R6: A Start low pulse of any width from 4 to 8 clocks is accepted. Its end is found from the line going high, and the block drives nothing during the pulse or its Recovery clock.
- R7: A Stop low pulse of 2 clocks sets `quiet_mode` to 1, and one of 3 clocks or more clears it. The new value is visible in the clock after the first high clock that follows the pulse.
- R8: In Quiet mode, while the line is Idle, the block raises a request only when an input with its `slot_en` bit at 1 differs from the level it sent in the previous cycle. It then drives 0 for exactly one clock and releases the line, without ever driving 1.
- R9: No request is raised in Continuous mode, or at any time between a Start Frame and the end of the Stop Frame.
- R10: Let r be the first high clock after a Stop pulse. The line counts as Idle only from clock r+2, so the earliest request drive falls in clock r+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 16 | Interrupt levels for slots 0..15 |
| iochk_lvl | input | 1 | I/O-check level for slot 16 |
| slot_en | input | 17 | Slot assignment mask; a slot with bit 0 is never driven |
| line_in | input | 1 | Resolved level of the serial line |
| line_oe | output | 1 | Drive enable toward the line |
| line_out | output | 1 | Drive value when `line_oe` is 1 |
| quiet_mode | output | 1 | Mode learned from the last Stop pulse |

## Verification
The hardest point to reach is the narrow Idle window right after a Stop Frame. A Quiet-mode request has to appear in exactly the third clock after the first high clock that follows the Stop pulse, and must appear in no clock before that. The bench models the host and the pull-up on the shared wire. It changes the levels in the first clock after each Stop turn-around, so every request lands on that boundary. Some cycles change only masked slots, and some switch the mode back to Continuous first. Other cycles scramble the inputs in the middle of the frames, which tests the snapshot and the ban on requests while the line is Active.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    TRK_IDLE,
    TRK_REQ,
    TRK_START,
    TRK_START_TA,
    TRK_FRAMES,
    TRK_STOP_WAIT,
    TRK_STOP_LOW,
    TRK_STOP_TA
  } trk_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE,
    PH_RECOV,
    PH_TURN
  } slot_phase_e;

endpackage

// File: rtl/sirq_slot_counter.sv
module sirq_slot_counter
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 17,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output slot_phase_e      phase,
  output logic [IDX_W-1:0] index,
  output logic             last_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SAMPLE;
      index <= '0;
    end else if (!run) begin
      phase <= PH_SAMPLE;
      index <= '0;
    end else begin
      unique case (phase)
        PH_SAMPLE: phase <= PH_RECOV;
        PH_RECOV:  phase <= PH_TURN;
        default: begin
          phase <= PH_SAMPLE;
          index <= index + 1'b1;
        end
      endcase
    end
  end

  assign last_done = run && (phase == PH_TURN) && (index == LAST_IDX);

endmodule

// File: rtl/sirq_line_tracker.sv
module sirq_line_tracker
  import sirq_pkg::*;
#(
  parameter int STOP_QUIET_W = 2,
  parameter int WIDTH_CNT_W  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       req_fire,
  input  logic       frames_done,
  output trk_state_e state,
  output logic       quiet_mode
);

  localparam logic [WIDTH_CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [WIDTH_CNT_W-1:0] QUIET_LIM = WIDTH_CNT_W'(STOP_QUIET_W);

  trk_state_e             state_d;
  logic [WIDTH_CNT_W-1:0] low_cnt;

  always_comb begin
    state_d = state;
    unique case (state)
      TRK_IDLE: begin
        if (!line_in)                     state_d = TRK_START;
        else if (req_fire && quiet_mode)  state_d = TRK_REQ;
      end
      TRK_REQ:       state_d = TRK_START;
      TRK_START:     if (line_in) state_d = TRK_START_TA;
      TRK_START_TA:  state_d = TRK_FRAMES;
      TRK_FRAMES:    if (frames_done) state_d = TRK_STOP_WAIT;
      TRK_STOP_WAIT: if (!line_in) state_d = TRK_STOP_LOW;
      TRK_STOP_LOW:  if (line_in) state_d = TRK_STOP_TA;
      default:       state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TRK_IDLE;
      low_cnt    <= '0;
      quiet_mode <= 1'b0;
    end else begin
      state <= state_d;
      if (state == TRK_STOP_WAIT && !line_in) begin
        low_cnt <= WIDTH_CNT_W'(1);
      end else if (state == TRK_STOP_LOW && !line_in && low_cnt != CNT_MAX) begin
        low_cnt <= low_cnt + 1'b1;
      end
      if (state == TRK_STOP_LOW && line_in) begin
        quiet_mode <= (low_cnt <= QUIET_LIM);
      end
    end
  end

endmodule

// File: rtl/sirq_slot_driver.sv
module sirq_slot_driver
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 17,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] lvl,
  input  logic [NUM_SLOTS-1:0] en,
  input  trk_state_e           state,
  input  slot_phase_e          phase,
  input  logic [IDX_W-1:0]     index,
  input  logic                 quiet_mode,
  input  logic                 line_in,
  output logic                 req_fire,
  output logic                 line_oe,
  output logic                 line_out
);

  logic [NUM_SLOTS-1:0] sent_q;
  logic                 pending;
  logic                 pull_low;
  logic                 in_frames;

  // Captured in the Start Frame turn-around clock; doubles as "last sent".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '1;
    end else if (state == TRK_START_TA) begin
      sent_q <= lvl;
    end
  end

  assign pending   = |((lvl ^ sent_q) & en);
  assign req_fire  = quiet_mode && (state == TRK_IDLE) && line_in && pending;
  assign in_frames = (state == TRK_FRAMES);
  assign pull_low  = en[index] && !sent_q[index];

  assign line_oe  = (state == TRK_REQ) ||
                    (in_frames && (phase != PH_TURN) && pull_low);
  assign line_out = in_frames && (phase == PH_RECOV);

endmodule

// File: rtl/sirq_encoder.sv
module sirq_encoder
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ      = 16,
  parameter int STOP_QUIET_W = 2,
  parameter int WIDTH_CNT_W  = 3,
  localparam int NUM_SLOTS   = NUM_IRQ + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_lvl,
  input  logic                 iochk_lvl,
  input  logic [NUM_SLOTS-1:0] slot_en,
  input  logic                 line_in,
  output logic                 line_oe,
  output logic                 line_out,
  output logic                 quiet_mode
);

  localparam int IDX_W = $clog2(NUM_SLOTS);

  trk_state_e       trk_state;
  slot_phase_e      slot_phase;
  logic [IDX_W-1:0] slot_idx;
  logic             frames_done;
  logic             req_fire;

  sirq_line_tracker #(
    .STOP_QUIET_W(STOP_QUIET_W),
    .WIDTH_CNT_W (WIDTH_CNT_W)
  ) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .req_fire   (req_fire),
    .frames_done(frames_done),
    .state      (trk_state),
    .quiet_mode (quiet_mode)
  );

  sirq_slot_counter #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (trk_state == TRK_FRAMES),
    .phase    (slot_phase),
    .index    (slot_idx),
    .last_done(frames_done)
  );

  sirq_slot_driver #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_driver (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       ({iochk_lvl, irq_lvl}),
    .en        (slot_en),
    .state     (trk_state),
    .phase     (slot_phase),
    .index     (slot_idx),
    .quiet_mode(quiet_mode),
    .line_in   (line_in),
    .req_fire  (req_fire),
    .line_oe   (line_oe),
    .line_out  (line_out)
  );

endmodule

// File: rtl/sirq_encoder_chk.sv
module sirq_encoder_chk
  import sirq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        line_oe,
  input logic        line_out,
  input logic        quiet_mode,
  input trk_state_e  state,
  input slot_phase_e phase
);

  AST_TURN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TRK_FRAMES && phase == PH_TURN) |-> !line_oe); // R3

  AST_HIGH_ONLY_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_out) |-> (state == TRK_FRAMES && phase == PH_RECOV)); // R3

  AST_RECOV_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TRK_FRAMES && phase == PH_RECOV && line_oe) |-> $past(line_oe && !line_out)); // R3

  AST_REQ_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TRK_REQ) |=> !line_oe); // R8

  AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TRK_REQ) |-> ($past(state) == TRK_IDLE && quiet_mode)); // R9

  AST_MODE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_mode != $past(quiet_mode)) |-> (state == TRK_STOP_TA)); // R7

endmodule

bind sirq_encoder sirq_encoder_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_oe   (line_oe),
  .line_out  (line_out),
  .quiet_mode(quiet_mode),
  .state     (trk_state),
  .phase     (slot_phase)
);

// File: tb/sirq_encoder_tb_top.sv
module sirq_encoder_tb_top;
  localparam int N = 16;
  localparam int S = 17;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] irq_lvl;
  logic         iochk_lvl;
  logic [S-1:0] slot_en;
  logic         host_oe, host_val;
  logic         line_in, line_oe, line_out, quiet_mode;

  assign line_in = (line_oe ? line_out : 1'b1) & (host_oe ? host_val : 1'b1);

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [S-1:0] exp_sent;
  bit exp_quiet;

  sirq_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .iochk_lvl(iochk_lvl),
    .slot_en(slot_en), .line_in(line_in), .line_oe(line_oe),
    .line_out(line_out), .quiet_mode(quiet_mode)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic begin_clk();
    @(posedge clk); #1;
  endtask

  task automatic mid_clk();
    @(negedge clk);
  endtask

  function automatic bit want_req(logic [S-1:0] lv, logic [S-1:0] en);
    return exp_quiet && (((lv ^ exp_sent) & en) != '0);
  endfunction

  task automatic run_cycle(int start_w, int stop_w, int idle_before, int idle_stop,
                           bit scramble, logic [S-1:0] new_lvl, logic [S-1:0] new_en);
    bit req;
    logic [S-1:0] snap;
    // clock r+2: first Idle clock, new levels applied
    begin_clk();
    {iochk_lvl, irq_lvl} = new_lvl;
    slot_en = new_en;
    host_oe = 0;
    req = want_req(new_lvl, new_en);
    mid_clk();
    chk(!line_oe, "R10", "drive in first idle clock", line_oe, 0);
    if (req) begin
      begin_clk(); mid_clk();
      chk(line_oe && !line_out, "R8", "request drive", {line_oe, line_out}, 2'b10);
      for (int i = 1; i < start_w; i++) begin
        begin_clk(); host_oe = 1; host_val = 0; mid_clk();
        chk(!line_oe, "R8", "release after request", line_oe, 0);
      end
    end else begin
      for (int i = 0; i < idle_before; i++) begin
        begin_clk(); mid_clk();
        chk(!line_oe, exp_quiet ? "R8" : "R9", "unexpected request", line_oe, 0);
      end
      for (int i = 0; i < start_w; i++) begin
        begin_clk(); host_oe = 1; host_val = 0; mid_clk();
        chk(!line_oe, "R6", "drive during start", line_oe, 0);
      end
    end
    // Recovery of start
    begin_clk(); host_oe = 1; host_val = 1; mid_clk();
    chk(!line_oe, "R6", "drive in start recovery", line_oe, 0);
    // Turn-around of start: levels captured here
    begin_clk(); host_oe = 0; mid_clk();
    snap = {iochk_lvl, irq_lvl};
    chk(!line_oe, "R6", "drive in start turn", line_oe, 0);
    for (int k = 0; k < S; k++) begin
      for (int p = 0; p < 3; p++) begin
        bit drv;
        begin_clk();
        if (scramble && p == 0) {iochk_lvl, irq_lvl} = S'($urandom);
        mid_clk();
        drv = slot_en[k] && !snap[k];
        if (p == 0)
          chk(line_oe == drv && (!drv || !line_out), scramble ? "R5" : "R2",
              $sformatf("slot %0d sample", k), {line_oe, line_out}, {drv, 1'b0});
        else if (p == 1)
          chk(line_oe == drv && (!drv || line_out), drv ? "R3" : "R4",
              $sformatf("slot %0d recovery", k), {line_oe, line_out}, {drv, drv});
        else
          chk(!line_oe, scramble ? "R9" : "R3",
              $sformatf("slot %0d turn", k), line_oe, 0);
      end
    end
    for (int i = 0; i < idle_stop; i++) begin
      begin_clk(); mid_clk();
      chk(!line_oe, "R9", "drive before stop", line_oe, 0);
    end
    for (int i = 0; i < stop_w; i++) begin
      begin_clk(); host_oe = 1; host_val = 0; mid_clk();
      chk(!line_oe, "R9", "drive during stop", line_oe, 0);
    end
    begin_clk(); host_oe = 1; host_val = 1; mid_clk();
    chk(!line_oe, "R10", "drive in stop recovery", line_oe, 0);
    exp_quiet = (stop_w <= 2);
    begin_clk(); host_oe = 0; mid_clk();
    chk(quiet_mode == exp_quiet, "R7", "mode after stop", quiet_mode, exp_quiet);
    chk(!line_oe, "R10", "drive in stop turn", line_oe, 0);
    exp_sent = snap;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [S-1:0] lv;
    void'($urandom(32'h5eed_01a7));
    rst_n = 0; host_oe = 0; host_val = 1;
    irq_lvl = '1; iochk_lvl = 1; slot_en = '1;
    exp_sent = '1; exp_quiet = 0;
    repeat (3) @(negedge clk);
    chk(!line_oe && !quiet_mode, "R1", "reset state", {line_oe, quiet_mode}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(!line_oe && !quiet_mode, "R1", "after reset", {line_oe, quiet_mode}, 0);

    run_cycle(4, 3, 2, 0, 0, 17'h1_5a3c, '1);
    run_cycle(8, 2, 1, 2, 0, 17'h0_ff00, 17'h1_f0ff);
    lv = exp_sent ^ 17'h0_0008;
    run_cycle(5, 2, 0, 0, 0, lv, '1);
    run_cycle(6, 2, 3, 1, 0, exp_sent, '1);
    lv = exp_sent ^ 17'h0_0020;
    run_cycle(7, 3, 3, 0, 0, lv, ~17'h0_0020);
    lv = exp_sent ^ 17'h1_0001;
    run_cycle(4, 3, 4, 0, 1, lv, '1);
    run_cycle(5, 2, 1, 0, 1, 17'h0_0000, '1);
    run_cycle(8, 2, 1, 0, 0, 17'h1_ffff, '1);

    for (int n = 0; n < 40; n++) begin
      logic [S-1:0] en;
      en = S'($urandom) | S'($urandom);
      lv = ($urandom % 3 == 0) ? exp_sent : S'($urandom);
      run_cycle(4 + int'($urandom % 5), 2 + int'($urandom % 2), int'($urandom % 4),
                int'($urandom % 3), ($urandom % 4) == 0, lv, en);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule